// File: doc/BRIEF.md
# Pair-and-Spare Reconfiguration Switch

This block sits behind a bank of redundant modules that all compute the same result. It keeps two of them running as an active pair. Every clock it compares the pair's outputs bit for bit and forwards the output of the first pair member, called slot A, to the system. Each module also has an error-report line. The switch treats these lines as plain inputs and records every report permanently. When the two pair members disagree, the switch uses those records to decide which member failed. It then puts a healthy module into that slot, picking candidates in fixed index order.

A disagreement costs exactly one invalid output cycle. The selection changes on the same edge that registers the mismatch, so the new pair drives the output from the following cycle on. When no healthy module is left to replace a failed member, the switch keeps its pair as it is, raises a sticky exhausted flag and goes on reporting mismatches.

Top module: `pas_switch`

## Requirements
- R1: After reset, slot A holds module 0 and slot B holds module 1, no module is marked as excluded, and `mismatch`, `exhausted` and `out_valid` are low.
- R2: `mismatch` is high in the cycle after a clock edge at which the data of the two active modules differed in any bit, and low after an edge at which they were equal.
- R3: While the active pair agrees, neither `act_a` nor `act_b` changes, whatever the error reports show.
- R4: After each edge, `out_data` carries the data that the slot A module presented at that edge. `out_valid` is high only when the pair agreed at that edge, so it is low for the single swap cycle.
- R5: On a disagreement in which exactly one active member has an error recorded (reported at that edge or at any earlier edge), only that member's slot is refilled. The new module is the lowest-index module that has no error recorded and is not already active, so `act_a` and `act_b` always differ.
- R6: A module that has ever reported an error is never placed into a slot again until reset, even if its report line later clears.
- R7: On a disagreement in which both active members have errors recorded, both slots are refilled on the same edge. Slot A takes the lowest-index healthy module and slot B takes the next one.
- R8: If a disagreement needs more healthy replacements than remain, the pair is left unchanged and `exhausted` goes high and stays high until reset. Later mismatches are still reported.
- R9: On a disagreement in which neither active member has an error recorded, the pair is left unchanged and `exhausted` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_data | input | N_MOD*DATA_W | Module outputs, module i in bits [i*DATA_W +: DATA_W] |
| mod_err | input | N_MOD | Error report of each module, bit i for module i |
| out_data | output | DATA_W | Registered output of the slot A module |
| out_valid | output | 1 | High when the forwarded data came from an agreeing pair |
| mismatch | output | 1 | Registered disagreement of the active pair |
| act_a | output | IDX_W | Index of the module in slot A |
| act_b | output | IDX_W | Index of the module in slot B |
| exhausted | output | 1 | Sticky flag: a replacement was needed and none was available |

## Verification
The bound checker checks the cycle-level rules on every cycle:
- a mismatch follows every disagreement and only disagreements;
- the pair holds still while it agrees;
- the two slots never hold the same module;
- a newly placed module never has an error on record;
- every change of selection comes with an invalid output;
- the exhausted flag is sticky and rises without moving the pair.

Only the bench's scenarios can show which module priority order actually picks, and that both slots refill together. They also show that a fault with nobody to blame holds the pair, and that an error report on a passive spare, ignored at the time, still removes that spare from later choices.

// File: rtl/pas_pkg.sv
package pas_pkg;

    localparam int unsigned DEF_MODS  = 4;
    localparam int unsigned DEF_WIDTH = 16;

    // What a disagreement asks the selector to do
    typedef enum logic [1:0] {
        RC_HOLD    = 2'd0,
        RC_REPL_A  = 2'd1,
        RC_REPL_B  = 2'd2,
        RC_REPL_AB = 2'd3
    } rc_kind_e;

    // Compare result together with the health of both active members
    typedef struct packed {
        logic differ;
        logic bad_a;
        logic bad_b;
    } cmp_view_t;

    function automatic rc_kind_e rc_classify(cmp_view_t v);
        rc_kind_e k;
        if (!v.differ)               k = RC_HOLD;
        else if (v.bad_a && v.bad_b) k = RC_REPL_AB;
        else if (v.bad_a)            k = RC_REPL_A;
        else if (v.bad_b)            k = RC_REPL_B;
        else                         k = RC_HOLD;
        return k;
    endfunction

    // Number of healthy candidates a decision consumes
    function automatic int unsigned rc_need(rc_kind_e k);
        int unsigned n;
        case (k)
            RC_REPL_AB:           n = 2;
            RC_REPL_A, RC_REPL_B: n = 1;
            default:              n = 0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pas_pair_cmp.sv
module pas_pair_cmp #(
    parameter int unsigned N_MOD  = pas_pkg::DEF_MODS,
    parameter int unsigned DATA_W = pas_pkg::DEF_WIDTH,
    localparam int unsigned IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic [N_MOD-1:0][DATA_W-1:0] mod_data,
    input  logic [IDX_W-1:0]             sel_a,
    input  logic [IDX_W-1:0]             sel_b,
    output logic [DATA_W-1:0]            data_a,
    output logic                         differ
);
    logic [DATA_W-1:0] data_b;
    logic [DATA_W-1:0] bit_diff;

    assign data_a = mod_data[sel_a];
    assign data_b = mod_data[sel_b];

    // Bitwise exclusive-or, then reduce
    assign bit_diff = data_a ^ data_b;
    assign differ   = |bit_diff;

endmodule

// File: rtl/pas_spare_pick.sv
module pas_spare_pick #(
    parameter int unsigned N_MOD = pas_pkg::DEF_MODS,
    localparam int unsigned IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic [N_MOD-1:0] avail,
    output logic             hit1,
    output logic [IDX_W-1:0] idx1,
    output logic             hit2,
    output logic [IDX_W-1:0] idx2
);
    // Fixed priority: lowest index first, then the next one
    always_comb begin
        hit1 = 1'b0;
        hit2 = 1'b0;
        idx1 = '0;
        idx2 = '0;
        for (int i = 0; i < int'(N_MOD); i++) begin
            if (avail[i]) begin
                if (!hit1) begin
                    hit1 = 1'b1;
                    idx1 = IDX_W'(i);
                end else if (!hit2) begin
                    hit2 = 1'b1;
                    idx2 = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/pas_sel_ctrl.sv
module pas_sel_ctrl
    import pas_pkg::*;
#(
    parameter int unsigned N_MOD = pas_pkg::DEF_MODS,
    localparam int unsigned IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             differ,
    input  logic [N_MOD-1:0] mod_err,
    output logic [IDX_W-1:0] sel_a,
    output logic [IDX_W-1:0] sel_b,
    output logic             exhausted
);
    logic [N_MOD-1:0] excl_q, excl_nx;
    logic [N_MOD-1:0] avail;
    logic [IDX_W-1:0] sel_a_nx, sel_b_nx;
    logic             exh_set;
    logic             hit1, hit2;
    logic [IDX_W-1:0] idx1, idx2;
    cmp_view_t        view;
    rc_kind_e         kind;

    // Error records include reports arriving at this very edge
    assign excl_nx = excl_q | mod_err;

    always_comb begin
        avail        = ~excl_nx;
        avail[sel_a] = 1'b0;
        avail[sel_b] = 1'b0;
    end

    pas_spare_pick #(.N_MOD(N_MOD)) u_pick (
        .avail (avail),
        .hit1  (hit1),
        .idx1  (idx1),
        .hit2  (hit2),
        .idx2  (idx2)
    );

    assign view.differ = differ;
    assign view.bad_a  = excl_nx[sel_a];
    assign view.bad_b  = excl_nx[sel_b];
    assign kind        = rc_classify(view);

    always_comb begin
        sel_a_nx = sel_a;
        sel_b_nx = sel_b;
        exh_set  = 1'b0;
        case (kind)
            RC_REPL_A: begin
                if (hit1) sel_a_nx = idx1;
                else      exh_set  = 1'b1;
            end
            RC_REPL_B: begin
                if (hit1) sel_b_nx = idx1;
                else      exh_set  = 1'b1;
            end
            RC_REPL_AB: begin
                if (hit2) begin
                    sel_a_nx = idx1;
                    sel_b_nx = idx2;
                end else begin
                    exh_set = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_a     <= '0;
            sel_b     <= IDX_W'(1);
            excl_q    <= '0;
            exhausted <= 1'b0;
        end else begin
            sel_a     <= sel_a_nx;
            sel_b     <= sel_b_nx;
            excl_q    <= excl_nx;
            exhausted <= exhausted | exh_set;
        end
    end

endmodule

// File: rtl/pas_switch.sv
module pas_switch #(
    parameter int unsigned N_MOD  = pas_pkg::DEF_MODS,
    parameter int unsigned DATA_W = pas_pkg::DEF_WIDTH,
    localparam int unsigned IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_MOD-1:0][DATA_W-1:0] mod_data,
    input  logic [N_MOD-1:0]             mod_err,
    output logic [DATA_W-1:0]            out_data,
    output logic                         out_valid,
    output logic                         mismatch,
    output logic [IDX_W-1:0]             act_a,
    output logic [IDX_W-1:0]             act_b,
    output logic                         exhausted
);
    logic [DATA_W-1:0] pair_data;
    logic              pair_differ;

    pas_pair_cmp #(.N_MOD(N_MOD), .DATA_W(DATA_W)) u_cmp (
        .mod_data (mod_data),
        .sel_a    (act_a),
        .sel_b    (act_b),
        .data_a   (pair_data),
        .differ   (pair_differ)
    );

    pas_sel_ctrl #(.N_MOD(N_MOD)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .differ    (pair_differ),
        .mod_err   (mod_err),
        .sel_a     (act_a),
        .sel_b     (act_b),
        .exhausted (exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            mismatch  <= 1'b0;
        end else begin
            out_data  <= pair_data;
            out_valid <= ~pair_differ;
            mismatch  <= pair_differ;
        end
    end

endmodule

// File: rtl/pas_switch_chk.sv
module pas_switch_chk #(
    parameter int unsigned N_MOD  = pas_pkg::DEF_MODS,
    parameter int unsigned DATA_W = pas_pkg::DEF_WIDTH,
    localparam int unsigned IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_MOD-1:0][DATA_W-1:0] mod_data,
    input logic [N_MOD-1:0]             mod_err,
    input logic                         out_valid,
    input logic                         mismatch,
    input logic [IDX_W-1:0]             act_a,
    input logic [IDX_W-1:0]             act_b,
    input logic                         exhausted
);
    // Every error report seen so far, kept independently of the design
    logic [N_MOD-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= seen_q | mod_err;
    end

    assert_mismatch_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_data[act_a] != mod_data[act_b]) |=> mismatch);

    assert_agree_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_data[act_a] == mod_data[act_b]) |=> !mismatch);

    assert_pair_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (mod_data[act_a] == mod_data[act_b]) |=> ($stable(act_a) && $stable(act_b)));

    assert_swap_invalid_R4: assert property (@(posedge clk) disable iff (rst)
        ((act_a != $past(act_a)) || (act_b != $past(act_b))) |-> !out_valid);

    assert_slots_distinct_R5: assert property (@(posedge clk) disable iff (rst)
        act_a != act_b);

    assert_no_reuse_a_R6: assert property (@(posedge clk) disable iff (rst)
        (act_a != $past(act_a)) |-> !seen_q[act_a]);

    assert_no_reuse_b_R6: assert property (@(posedge clk) disable iff (rst)
        (act_b != $past(act_b)) |-> !seen_q[act_b]);

    assert_exh_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        exhausted |=> exhausted);

    assert_exh_holds_pair_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(exhausted) |-> ($stable(act_a) && $stable(act_b)));

endmodule

bind pas_switch pas_switch_chk #(.N_MOD(N_MOD), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_data  (mod_data),
    .mod_err   (mod_err),
    .out_valid (out_valid),
    .mismatch  (mismatch),
    .act_a     (act_a),
    .act_b     (act_b),
    .exhausted (exhausted)
);

// File: tb/test_pas_switch.sv
`timescale 1ns/1ps
module test_pas_switch;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int IW = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic [N-1:0][W-1:0] mod_data;
    logic [N-1:0]        mod_err;
    logic [W-1:0]        out_data;
    logic                out_valid, mismatch, exhausted;
    logic [IW-1:0]       act_a, act_b;

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements
    int           ea, eb;
    logic [N-1:0] ex;
    bit           exh;
    logic [W-1:0] e_data;
    bit           e_valid, e_mis;

    always #4 clk = ~clk;   // 125 MHz

    pas_switch #(.N_MOD(N), .DATA_W(W)) i_pas_switch (
        .clk(clk), .rst(rst), .mod_data(mod_data), .mod_err(mod_err),
        .out_data(out_data), .out_valid(out_valid), .mismatch(mismatch),
        .act_a(act_a), .act_b(act_b), .exhausted(exhausted)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 out_data", out_data, e_data);
        chk("R4 out_valid", out_valid, e_valid);
        chk("R2 mismatch", mismatch, e_mis);
        chk("R3 R5 R6 R7 R9 act_a", act_a, ea);
        chk("R3 R5 R6 R7 R9 act_b", act_b, eb);
        chk("R8 exhausted", exhausted, exh);
    endtask

    task automatic model_update(input logic [N-1:0][W-1:0] d, input logic [N-1:0] e);
        logic [N-1:0] exn;
        bit differ, bad_a, bad_b;
        int c1, c2;
        differ  = (d[ea] != d[eb]);
        e_data  = d[ea];
        e_valid = !differ;
        e_mis   = differ;
        exn     = ex | e;
        bad_a   = exn[ea];
        bad_b   = exn[eb];
        c1 = -1;
        c2 = -1;
        for (int i = 0; i < N; i++) begin
            if (!exn[i] && i != ea && i != eb) begin
                if (c1 < 0) c1 = i;
                else if (c2 < 0) c2 = i;
            end
        end
        if (differ && bad_a && bad_b) begin
            if (c2 >= 0) begin ea = c1; eb = c2; end
            else exh = 1;
        end else if (differ && bad_a) begin
            if (c1 >= 0) ea = c1; else exh = 1;
        end else if (differ && bad_b) begin
            if (c1 >= 0) eb = c1; else exh = 1;
        end
        ex = exn;
    endtask

    task automatic step(input logic [N-1:0][W-1:0] d, input logic [N-1:0] e);
        compare_all();
        mod_data = d;
        mod_err  = e;
        model_update(d, e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        mod_data = '0;
        mod_err  = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ea = 0; eb = 1; ex = '0; exh = 0;
        e_data = '0; e_valid = 0; e_mis = 0;
        chk("R1 act_a", act_a, 0);
        chk("R1 act_b", act_b, 1);
        chk("R1 mismatch", mismatch, 0);
        chk("R1 exhausted", exhausted, 0);
        chk("R1 out_valid", out_valid, 0);
    endtask

    function automatic logic [N-1:0][W-1:0] all_same(input logic [W-1:0] v);
        logic [N-1:0][W-1:0] d;
        for (int i = 0; i < N; i++) d[i] = v;
        return d;
    endfunction

    task automatic rand_step();
        logic [N-1:0][W-1:0] d;
        logic [N-1:0] e;
        int r, m;
        d = all_same(W'($urandom));
        e = '0;
        r = int'($urandom % 8);
        m = int'($urandom % N);
        if (r < 3) d[m][$urandom % W] ^= 1'b1;
        if (r == 0) e[m] = 1'b1;
        if ($urandom % 10 == 0) e[$urandom % N] = 1'b1;
        step(d, e);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0][W-1:0] d;
        void'($urandom(32'd20240611));
        do_reset();

        // Agreeing pair with an error on a passive spare: nothing moves (R3)
        step(all_same(16'h1111), 4'b0000);
        step(all_same(16'h2222), 4'b0100);
        compare_all();
        chk("R3 pair held while agreeing", {act_a, act_b}, {2'd0, 2'd1});

        // Module 1 fails and reports; spare 2 was excluded earlier, so 3 is used (R5, R6)
        d = all_same(16'h3333); d[1] = 16'h3330;
        step(d, 4'b0010);
        compare_all();
        chk("R4 swap cycle invalid", out_valid, 0);
        chk("R6 excluded spare skipped", act_b, 3);
        step(all_same(16'h4444), 4'b0000);

        // Disagreement with nobody flagged: pair held (R9)
        d = all_same(16'h5555); d[0] = 16'h5554;
        step(d, 4'b0000);
        compare_all();
        chk("R9 pair held a", act_a, 0);
        chk("R9 pair held b", act_b, 3);
        chk("R9 no exhaustion", exhausted, 0);

        // Module 3 fails, no spare left (R8)
        d = all_same(16'h6666); d[3] = 16'h6676;
        step(d, 4'b1000);
        compare_all();
        chk("R8 exhausted raised", exhausted, 1);
        chk("R8 pair kept", {act_a, act_b}, {2'd0, 2'd3});
        d = all_same(16'h7777); d[3] = 16'h7707;
        step(d, 4'b0000);
        compare_all();
        chk("R8 mismatch still reported", mismatch, 1);

        // Both members fail together (R7)
        do_reset();
        d = all_same(16'h8888); d[0] = 16'h8889; d[1] = 16'h888A;
        step(d, 4'b0011);
        compare_all();
        chk("R7 slot A lowest spare", act_a, 2);
        chk("R7 slot B next spare", act_b, 3);

        // Random episodes
        for (int ep = 0; ep < 12; ep++) begin
            do_reset();
            for (int k = 0; k < 50; k++) rand_step();
        end
        compare_all();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule